// File: doc/BRIEF.md
# Per-Context Local Register Window

This block holds the small set of per-context interrupt registers that each processor context owns: a control word, a pending word, an enable mask, a compare routing word, an indirection pointer and an identity word. It also passes through the compare-low register of a timer that lives outside the block. Every request on the register bus carries the index of the context that issues it. Address bit 7 selects one of two windows. The local window (bit 7 = 0) addresses the requester's own registers. The other window (bit 7 = 1) addresses the context whose index the requester has stored in its own pointer register. Both windows share one offset decode and differ only in how the target context is picked.

The mask, the compare routing word and the compare-pending bit of every context leave the block continuously, for use by the interrupt router. Writes to compare-low are forwarded to the timer in the same cycle as the request, together with the target context. Reads of compare-low return the timer's value for the target context. When the timer expires for a context, that context's compare-pending bit is set.

Top module: `ctxwin_top`

## Requirements
- R1: A request with addr_i[7]=0 targets the context given by req_ctx_i. A request with addr_i[7]=1 targets the context held in the pointer register (offset 0x18) of the context req_ctx_i.
- R2: A write to the pointer register at offset 0x18 is ignored when the full 32-bit write value is not less than NUM_CTX. Otherwise the register takes that value.
- R3: A write to offset 0x0C ORs wdata_i[5:0] into the target's 6-bit mask. A write to offset 0x10 clears the mask bits that are set in wdata_i[5:0]. The mask reads at offset 0x08 with bits 31:6 equal to 0, and writes to 0x08 are ignored.
- R4: A read of offset 0x1C returns the index of the target context.
- R5: The control register (offset 0x00) reads 0 and ignores writes. A write to the compare routing word (offset 0x14) is rejected when wdata_i[5:0] > 5. Otherwise the routing word keeps only bit 31 (route enable) and bits 5:0 (pin) of the write.
- R6: After reset, every context has pending 0, pointer 0, mask 0x32 and compare routing word 0x8000_0000, and rdata_o is 0.
- R7: The compare-high offset 0x24 reads 0. Any offset not listed in R2 to R8 (this includes 0x0C, 0x10 and unaligned offsets) reads 0, and writes to such offsets change nothing.
- R8: A write to offset 0x20 asserts cmp_we_o in the same cycle, with cmp_ctx_o equal to the target and cmp_wdata_o equal to wdata_i. The same write clears the target's compare-pending bit. A read of offset 0x20 returns the slice of cmp_rdata_i that belongs to the target.
- R9: cmp_expire_i[c] sets the compare-pending bit of context c on the next clock. That bit reads as bit 1 of offset 0x04. When an expiry and a compare-low write to the same context fall in the same cycle, the bit ends up set.
- R10: Read data appears on rdata_o in the cycle after the read request. In the cycle after any non-read cycle, rdata_o is 0.
- R11: mask_o, cmap_o and pend_o always show each context's current mask, compare routing word and compare-pending bit, with context c in slice c.

Top module port list follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register request valid |
| we_i | input | 1 | 1 = write, 0 = read |
| req_ctx_i | input | CTX_W | Index of the requesting context |
| addr_i | input | 8 | Bit 7 selects the window, bits 6:0 are the byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| cmp_expire_i | input | NUM_CTX | Timer expiry pulse, one bit per context |
| cmp_rdata_i | input | NUM_CTX*32 | Timer compare-low value for each context |
| cmp_we_o | output | 1 | Compare-low write forwarded to the timer |
| cmp_ctx_o | output | CTX_W | Context of the forwarded write |
| cmp_wdata_o | output | 32 | Data of the forwarded write |
| mask_o | output | NUM_CTX*6 | Per-context enable mask |
| cmap_o | output | NUM_CTX*32 | Per-context compare routing word |
| pend_o | output | NUM_CTX | Per-context compare-pending bit |

## Verification
An expiry pulse from the timer and a compare-low write that clears the same context's pending bit can land on one clock edge. The bench provokes this directly: it drives cmp_expire_i for a context in the same cycle as a compare-low write to that context, once through the local window and once through the other window. The result is judged on pend_o and on a later read of the pending offset, which must both show the bit set. A second overlap comes from randomized traffic: a pointer write and an other-window access issued back to back, where the other-window access must already use the new pointer value.

// File: rtl/ctxwin_pkg.sv
package ctxwin_pkg;
  localparam int DATA_W  = 32;
  localparam int ADDR_W  = 8;
  localparam int OFF_W   = 7;
  localparam int MASK_W  = 6;
  localparam int PIN_W   = 6;
  localparam int PIN_MAX = 5;
  localparam int MAP_EN  = 31;
  localparam int CMP_BIT = 1;
  localparam logic [MASK_W-1:0] MASK_RST = 6'h32;

  localparam logic [OFF_W-1:0] OFF_CTL   = 7'h00;
  localparam logic [OFF_W-1:0] OFF_PEND  = 7'h04;
  localparam logic [OFF_W-1:0] OFF_MASK  = 7'h08;
  localparam logic [OFF_W-1:0] OFF_MSET  = 7'h0C;
  localparam logic [OFF_W-1:0] OFF_MCLR  = 7'h10;
  localparam logic [OFF_W-1:0] OFF_CMAP  = 7'h14;
  localparam logic [OFF_W-1:0] OFF_OADDR = 7'h18;
  localparam logic [OFF_W-1:0] OFF_IDENT = 7'h1C;
  localparam logic [OFF_W-1:0] OFF_CMPLO = 7'h20;
  localparam logic [OFF_W-1:0] OFF_CMPHI = 7'h24;

  typedef struct packed {
    logic mset;
    logic mclr;
    logic cmap;
    logic oaddr;
    logic cmplo;
  } wr_strb_t;

  typedef enum logic [2:0] {
    RS_ZERO, RS_PEND, RS_MASK, RS_CMAP, RS_OADDR, RS_IDENT, RS_CMPLO
  } rd_sel_e;
endpackage

// File: rtl/ctxwin_sel.sv
module ctxwin_sel #(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  logic [CTX_W-1:0]         req_ctx_i,
  input  logic                     other_i,
  input  logic [NUM_CTX*CTX_W-1:0] oaddr_flat_i,
  output logic [CTX_W-1:0]         tgt_o,
  output logic                     tgt_ok_o
);
  logic [CTX_W-1:0] safe_idx;
  logic [CTX_W-1:0] ptr;

  assign tgt_ok_o = (32'(req_ctx_i) < NUM_CTX);
  assign safe_idx = tgt_ok_o ? req_ctx_i : '0;
  assign ptr      = oaddr_flat_i[safe_idx*CTX_W +: CTX_W];
  assign tgt_o    = other_i ? ptr : req_ctx_i;
endmodule

// File: rtl/ctxwin_decode.sv
module ctxwin_decode
  import ctxwin_pkg::*;
(
  input  logic             req_i,
  input  logic             we_i,
  input  logic             ok_i,
  input  logic [OFF_W-1:0] off_i,
  output wr_strb_t         strb_o,
  output rd_sel_e          rd_sel_o,
  output logic             rd_en_o
);
  logic wr_en;

  assign wr_en   = req_i && we_i && ok_i;
  assign rd_en_o = req_i && !we_i && ok_i;

  always_comb begin
    strb_o       = '0;
    strb_o.mset  = wr_en && (off_i == OFF_MSET);
    strb_o.mclr  = wr_en && (off_i == OFF_MCLR);
    strb_o.cmap  = wr_en && (off_i == OFF_CMAP);
    strb_o.oaddr = wr_en && (off_i == OFF_OADDR);
    strb_o.cmplo = wr_en && (off_i == OFF_CMPLO);
  end

  always_comb begin
    case (off_i)
      OFF_PEND:  rd_sel_o = RS_PEND;
      OFF_MASK:  rd_sel_o = RS_MASK;
      OFF_CMAP:  rd_sel_o = RS_CMAP;
      OFF_OADDR: rd_sel_o = RS_OADDR;
      OFF_IDENT: rd_sel_o = RS_IDENT;
      OFF_CMPLO: rd_sel_o = RS_CMPLO;
      default:   rd_sel_o = RS_ZERO; // control, compare-high, write-only, unknown
    endcase
  end
endmodule

// File: rtl/ctxwin_slot.sv
module ctxwin_slot
  import ctxwin_pkg::*;
#(
  parameter int NUM_CTX = 4,
  parameter int CTX_W   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              hit_i,
  input  wr_strb_t          strb_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_i,
  output logic [MASK_W-1:0] mask_o,
  output logic [DATA_W-1:0] cmap_o,
  output logic [CTX_W-1:0]  oaddr_o,
  output logic              pend_o
);
  logic [MASK_W-1:0] mask_q;
  logic              map_en_q;
  logic [PIN_W-1:0]  map_pin_q;
  logic [CTX_W-1:0]  oaddr_q;
  logic              pend_q;
  logic              cmap_ok;
  logic              oaddr_ok;

  assign cmap_ok  = (wdata_i[PIN_W-1:0] <= PIN_W'(PIN_MAX));
  assign oaddr_ok = (wdata_i < DATA_W'(NUM_CTX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q    <= MASK_RST;
      map_en_q  <= 1'b1;
      map_pin_q <= '0;
      oaddr_q   <= '0;
      pend_q    <= 1'b0;
    end else begin
      if (hit_i && strb_i.mset) mask_q <= mask_q | wdata_i[MASK_W-1:0];
      else if (hit_i && strb_i.mclr) mask_q <= mask_q & ~wdata_i[MASK_W-1:0];
      if (hit_i && strb_i.cmap && cmap_ok) begin
        map_en_q  <= wdata_i[MAP_EN];
        map_pin_q <= wdata_i[PIN_W-1:0];
      end
      if (hit_i && strb_i.oaddr && oaddr_ok) oaddr_q <= wdata_i[CTX_W-1:0];
      // expiry beats the clear of a same-cycle compare write
      if (expire_i) pend_q <= 1'b1;
      else if (hit_i && strb_i.cmplo) pend_q <= 1'b0;
    end
  end

  assign mask_o  = mask_q;
  assign cmap_o  = {map_en_q, {(DATA_W-PIN_W-1){1'b0}}, map_pin_q};
  assign oaddr_o = oaddr_q;
  assign pend_o  = pend_q;

  assert_oaddr_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(oaddr_q) < NUM_CTX);
  assert_mask_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_i && (strb_i.mset || strb_i.mclr)) |=> $stable(mask_q));
  assert_cmap_pin_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    map_pin_q <= PIN_W'(PIN_MAX));
  assert_pend_set_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire_i |=> pend_q);
endmodule

// File: rtl/ctxwin_top.sv
module ctxwin_top
  import ctxwin_pkg::*;
#(
  parameter int NUM_CTX = 4,
  localparam int CTX_W  = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [CTX_W-1:0]          req_ctx_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [DATA_W-1:0]         wdata_i,
  output logic [DATA_W-1:0]         rdata_o,
  input  logic [NUM_CTX-1:0]        cmp_expire_i,
  input  logic [NUM_CTX*DATA_W-1:0] cmp_rdata_i,
  output logic                      cmp_we_o,
  output logic [CTX_W-1:0]          cmp_ctx_o,
  output logic [DATA_W-1:0]         cmp_wdata_o,
  output logic [NUM_CTX*MASK_W-1:0] mask_o,
  output logic [NUM_CTX*DATA_W-1:0] cmap_o,
  output logic [NUM_CTX-1:0]        pend_o
);
  logic [CTX_W-1:0]         tgt;
  logic                     tgt_ok;
  logic [NUM_CTX*CTX_W-1:0] oaddr_flat;
  wr_strb_t                 strb;
  rd_sel_e                  rd_sel;
  logic                     rd_en;
  logic [DATA_W-1:0]        rd_val;
  logic [DATA_W-1:0]        rdata_q;

  logic [MASK_W-1:0] mask_a  [NUM_CTX];
  logic [DATA_W-1:0] cmap_a  [NUM_CTX];
  logic [CTX_W-1:0]  oaddr_a [NUM_CTX];
  logic              pend_a  [NUM_CTX];

  ctxwin_sel #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_sel (
    .req_ctx_i   (req_ctx_i),
    .other_i     (addr_i[ADDR_W-1]),
    .oaddr_flat_i(oaddr_flat),
    .tgt_o       (tgt),
    .tgt_ok_o    (tgt_ok)
  );

  ctxwin_decode u_dec (
    .req_i   (req_i),
    .we_i    (we_i),
    .ok_i    (tgt_ok),
    .off_i   (addr_i[OFF_W-1:0]),
    .strb_o  (strb),
    .rd_sel_o(rd_sel),
    .rd_en_o (rd_en)
  );

  for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
    ctxwin_slot #(.NUM_CTX(NUM_CTX), .CTX_W(CTX_W)) u_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .hit_i   (32'(tgt) == c),
      .strb_i  (strb),
      .wdata_i (wdata_i),
      .expire_i(cmp_expire_i[c]),
      .mask_o  (mask_a[c]),
      .cmap_o  (cmap_a[c]),
      .oaddr_o (oaddr_a[c]),
      .pend_o  (pend_a[c])
    );
    assign oaddr_flat[c*CTX_W +: CTX_W]  = oaddr_a[c];
    assign mask_o[c*MASK_W +: MASK_W]    = mask_a[c];
    assign cmap_o[c*DATA_W +: DATA_W]    = cmap_a[c];
    assign pend_o[c]                     = pend_a[c];
  end

  always_comb begin
    rd_val = '0;
    case (rd_sel)
      RS_PEND:  rd_val[CMP_BIT] = pend_a[tgt];
      RS_MASK:  rd_val = DATA_W'(mask_a[tgt]);
      RS_CMAP:  rd_val = cmap_a[tgt];
      RS_OADDR: rd_val = DATA_W'(oaddr_a[tgt]);
      RS_IDENT: rd_val = DATA_W'(tgt);
      RS_CMPLO: rd_val = cmp_rdata_i[tgt*DATA_W +: DATA_W];
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_en ? rd_val : '0;
  end

  assign rdata_o     = rdata_q;
  assign cmp_we_o    = strb.cmplo;
  assign cmp_ctx_o   = tgt;
  assign cmp_wdata_o = wdata_i;

  assert_ctl_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && addr_i[OFF_W-1:0] == OFF_CTL) |=> rdata_o == '0);
  assert_ident_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && tgt_ok && addr_i[OFF_W-1:0] == OFF_IDENT)
      |=> rdata_o == DATA_W'($past(tgt)));
  assert_idle_zero_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && !we_i) |=> rdata_o == '0);
  assert_cmp_fwd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_we_o |-> (req_i && we_i && cmp_wdata_o == wdata_i));
endmodule

// File: tb/sim_ctxwin_top.sv
module sim_ctxwin_top;
  localparam int N = 4;
  localparam int CW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, we = 1'b0;
  logic [CW-1:0] ctx = '0;
  logic [7:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [N-1:0]  ex = '0;
  logic [N*32-1:0] cmp_rd;
  logic [31:0]   rdata;
  logic          cmp_we;
  logic [CW-1:0] cmp_ctx;
  logic [31:0]   cmp_wd;
  logic [N*6-1:0]  mask;
  logic [N*32-1:0] cmap;
  logic [N-1:0]    pend;
  string         tag_in = "R6";

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  ctxwin_top #(.NUM_CTX(N)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .req_ctx_i(ctx),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .cmp_expire_i(ex),
    .cmp_rdata_i(cmp_rd), .cmp_we_o(cmp_we), .cmp_ctx_o(cmp_ctx),
    .cmp_wdata_o(cmp_wd), .mask_o(mask), .cmap_o(cmap), .pend_o(pend)
  );

  // reference state
  logic [5:0]  m_mask [N];
  logic [31:0] m_cmap [N];
  int          m_oaddr [N];
  bit          m_pend [N];
  logic [31:0] m_rdata;
  string       m_tag;

  function automatic int tgt_of();
    return addr[7] ? m_oaddr[ctx] : int'(ctx);
  endfunction

  function automatic logic [31:0] rd_model(int t, int off);
    case (off)
      'h04: return m_pend[t] ? 32'h2 : 32'h0;
      'h08: return {26'b0, m_mask[t]};
      'h14: return m_cmap[t];
      'h18: return 32'(m_oaddr[t]);
      'h1C: return 32'(t);
      'h20: return cmp_rd[t*32 +: 32];
      default: return 32'h0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin
        m_mask[i] <= 6'h32; m_cmap[i] <= 32'h8000_0000;
        m_oaddr[i] <= 0; m_pend[i] <= 1'b0;
      end
      m_rdata <= '0; m_tag <= "R6";
    end else begin
      if (req && !we) begin
        m_rdata <= rd_model(tgt_of(), int'(addr[6:0]));
        m_tag <= tag_in;
      end else begin
        m_rdata <= '0; m_tag <= "R10";
      end
      if (req && we) begin
        case (int'(addr[6:0]))
          'h0C: m_mask[tgt_of()] <= m_mask[tgt_of()] | wdata[5:0];
          'h10: m_mask[tgt_of()] <= m_mask[tgt_of()] & ~wdata[5:0];
          'h14: if (wdata[5:0] <= 6'd5) m_cmap[tgt_of()] <= wdata & 32'h8000_003F;
          'h18: if (wdata < N) m_oaddr[tgt_of()] <= int'(wdata);
          default: ;
        endcase
      end
      for (int i = 0; i < N; i++) begin
        if (ex[i]) m_pend[i] <= 1'b1;
        else if (req && we && addr[6:0] == 7'h20 && tgt_of() == i) m_pend[i] <= 1'b0;
      end
    end
  end

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tg, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit exp_we;
    chk(m_tag, "rdata_o", rdata, m_rdata);
    for (int i = 0; i < N; i++) begin
      chk("R11", "mask_o", 32'(mask[i*6 +: 6]), 32'(m_mask[i]));
      chk("R11", "cmap_o", cmap[i*32 +: 32], m_cmap[i]);
      chk("R9", "pend_o", 32'(pend[i]), 32'(m_pend[i]));
    end
    exp_we = rst_n && req && we && addr[6:0] == 7'h20;
    chk("R8", "cmp_we_o", 32'(cmp_we), 32'(exp_we));
    if (exp_we) begin
      chk("R8", "cmp_ctx_o", 32'(cmp_ctx), 32'(tgt_of()));
      chk("R8", "cmp_wdata_o", cmp_wd, wdata);
    end
  endtask

  task automatic step(bit rq, bit w, int c, bit oth, int off, logic [31:0] d,
                      logic [N-1:0] e, string tg);
    @(negedge clk);
    check_all();
    req = rq; we = w; ctx = CW'(c); addr = {oth, 7'(off)}; wdata = d; ex = e;
    tag_in = tg;
  endtask

  task automatic wr(int c, bit oth, int off, logic [31:0] d, string tg);
    step(1'b1, 1'b1, c, oth, off, d, '0, tg);
  endtask
  task automatic rd(int c, bit oth, int off, string tg);
    step(1'b1, 1'b0, c, oth, off, 32'h0, '0, tg);
  endtask
  task automatic idle();
    step(1'b0, 1'b0, 0, 1'b0, 0, 32'h0, '0, "R10");
  endtask

  initial begin
    for (int i = 0; i < N; i++) cmp_rd[i*32 +: 32] = 32'hC0DE_0000 + 32'(i);
    repeat (3) @(negedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R6 reset values read through the local window
    for (int c = 0; c < N; c++) begin
      rd(c, 0, 'h00, "R6"); rd(c, 0, 'h04, "R6"); rd(c, 0, 'h08, "R6");
      rd(c, 0, 'h14, "R6"); rd(c, 0, 'h18, "R6");
    end
    // R2 pointer: valid, out of range, large
    wr(0, 0, 'h18, 32'd2, "R2"); rd(0, 0, 'h18, "R2");
    wr(0, 0, 'h18, 32'd4, "R2"); rd(0, 0, 'h18, "R2");
    wr(0, 0, 'h18, 32'h1000_0001, "R2"); rd(0, 0, 'h18, "R2");
    // R1 R4 identity through both windows
    rd(0, 0, 'h1C, "R4"); rd(0, 1, 'h1C, "R1"); rd(3, 1, 'h1C, "R1");
    wr(1, 0, 'h18, 32'd3, "R1"); rd(1, 1, 'h1C, "R4");
    // R3 mask set/clear with stray bits, write to read offset
    wr(2, 0, 'h0C, 32'hFFFF_FF01, "R3"); rd(2, 0, 'h08, "R3");
    wr(0, 1, 'h10, 32'hFFFF_FF30, "R3"); rd(2, 0, 'h08, "R3");
    wr(2, 0, 'h08, 32'h0000_003F, "R3"); rd(2, 0, 'h08, "R3");
    // R5 control and compare routing
    wr(1, 0, 'h00, 32'hFFFF_FFFF, "R5"); rd(1, 0, 'h00, "R5");
    wr(1, 0, 'h14, 32'h7FFF_FF03, "R5"); rd(1, 0, 'h14, "R5");
    wr(1, 0, 'h14, 32'h8000_0006, "R5"); rd(1, 0, 'h14, "R5");
    wr(1, 1, 'h14, 32'h8000_0005, "R5"); rd(3, 0, 'h14, "R5");
    // R7 compare-high and unknown offsets
    rd(0, 0, 'h24, "R7"); rd(0, 0, 'h0C, "R7"); rd(0, 0, 'h02, "R7");
    wr(0, 0, 'h28, 32'hFFFF_FFFF, "R7"); wr(0, 0, 'h09, 32'h3F, "R7");
    rd(0, 0, 'h08, "R7"); rd(0, 0, 'h7C, "R7");
    // R8 compare-low forward and read
    rd(2, 0, 'h20, "R8"); rd(0, 1, 'h20, "R8");
    step(1'b0, 1'b0, 0, 0, 0, 0, 4'b0110, "R9"); rd(1, 0, 'h04, "R9");
    wr(1, 0, 'h20, 32'h1234_5678, "R8"); rd(1, 0, 'h04, "R8");
    // R9 expiry in the same cycle as a clearing write
    step(1'b1, 1'b1, 2, 0, 'h20, 32'hAAAA_0000, 4'b0100, "R9"); rd(2, 0, 'h04, "R9");
    step(1'b1, 1'b1, 1, 1, 'h20, 32'h5555_0000, 4'b1000, "R9"); rd(3, 0, 'h04, "R9");
    // R10 idle after reads
    rd(0, 0, 'h1C, "R10"); idle(); idle();
    for (int i = 0; i < N; i++) cmp_rd[i*32 +: 32] = 32'h0BAD_0000 ^ (32'(i) << 8);
    // mixed traffic
    for (int k = 0; k < 1500; k++) begin
      int offs [12] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h1C, 'h20, 'h24, 'h28, 'h06};
      int o = offs[$urandom_range(11)];
      logic [31:0] d = $urandom;
      if (o == 'h18) d = 32'($urandom_range(5));
      if (o == 'h14) d = {d[31], 25'b0, 3'b0, d[2:0]};
      step(1'($urandom_range(3) != 0), 1'($urandom_range(1)), $urandom_range(N-1),
           1'($urandom_range(1)), o, d,
           ($urandom_range(7) == 0) ? N'($urandom) : '0, "R1");
    end
    idle(); idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule